// File: doc/BRIEF.md
# Receive Byte Queue with Error Tallies

This block is the receive-side byte queue of an asynchronous serial port. A receiver front end hands it one byte at a time, together with two flags that say whether that byte failed its parity check or its stop-bit (framing) check. The queue keeps up to 64 entries, each holding the byte and both flags. Bytes leave in arrival order. The entry at the head of the queue is always visible on the read outputs, and a pop strobe discards it.

Next to the storage, the block keeps two tallies. One counts the stored entries that carry a parity flag and the other counts those that carry a framing flag. A tally goes up when a flagged byte enters and down when a flagged byte leaves. Both tallies are packed into a 16-bit read-only count word. Each field is 6 bits wide, so a field that has counted all 64 entries wraps and reads zero. An error-pending output still reports that case correctly. When the mode input selects synchronous operation, the count word and the error-pending output read zero.

Top module: `rxq_err_fifo`

## Requirements
- R1: After a synchronous active-low reset, `empty`=1, `full`=0, `level`=0, `err_count_word`=0, `err_pending`=0 and `overrun`=0.
- R2: Bytes come out in the order they were accepted. `pop_data`, `pop_perr` and `pop_ferr` show the oldest stored entry without waiting for a pop, and `level` counts the stored entries.
- R3: `full`=1 when 64 entries are stored. A push while `full`=1 is dropped, even if a pop comes in the same cycle, and the stored entries stay intact. The drop sets `overrun` to 1, and `overrun` stays at 1 until reset.
- R4: A pop while `empty`=1 changes nothing. While `empty`=1, `pop_data`, `pop_perr` and `pop_ferr` read 0.
- R5: In asynchronous mode, `err_count_word[13:8]` holds the number of stored entries whose parity flag is set, modulo 64.
- R6: In asynchronous mode, `err_count_word[5:0]` holds the number of stored entries whose framing flag is set, modulo 64.
- R7: `err_count_word[15:14]` and `err_count_word[7:6]` always read 0.
- R8: When all 64 stored entries carry the same flag, that field reads 0 while `err_pending` reads 1.
- R9: When a push and a pop are both accepted in the same cycle, `level` does not change. Each tally changes by the pushed flag minus the popped flag.
- R10: While `async_mode`=0, `err_count_word` and `err_pending` read 0. The tallies keep following the queue during that time, so setting `async_mode` back to 1 shows the true counts.
- R11: In asynchronous mode, `err_pending`=1 exactly when at least one stored entry carries a parity flag or a framing flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| async_mode | input | 1 | 1 = asynchronous mode, 0 = synchronous mode (counts read 0) |
| push | input | 1 | Write strobe from the receiver front end |
| push_data | input | 8 | Received byte |
| push_perr | input | 1 | Parity flag of the received byte |
| push_ferr | input | 1 | Framing flag of the received byte |
| pop | input | 1 | Discard the head entry |
| pop_data | output | 8 | Byte at the head of the queue (0 when empty) |
| pop_perr | output | 1 | Parity flag of the head entry |
| pop_ferr | output | 1 | Framing flag of the head entry |
| full | output | 1 | Queue holds 64 entries |
| empty | output | 1 | Queue holds no entries |
| level | output | 7 | Number of stored entries, 0 to 64 |
| err_count_word | output | 16 | Packed count word: parity count in bits 13:8, framing count in bits 5:0 |
| err_pending | output | 1 | At least one stored entry carries an error flag |
| overrun | output | 1 | Sticky flag: a push was dropped because the queue was full |

## Verification
The bench fills the queue with 64 entries that all carry a parity flag. A design that hid the wrap behind 6-bit state would either read 0 in that field with `err_pending` low, or leak the wrap into bit 14. Pushing into the full queue, with and without a pop in the same cycle, catches a design that overwrites the oldest byte or lets the level climb to 65. Mixed push-and-pop cycles whose flags differ catch a tally that counts only the push or only the pop. The bench also switches to synchronous mode and back, which catches a design that clears the tallies in synchronous mode instead of only masking them.

// File: rtl/rxq_pkg.sv
// Package: shared entry type and fixed layout constants of the count word.
// Assumes byte-wide data and two error flags per entry.
package rxq_pkg;
    localparam int DATA_W  = 8;
    localparam int FIELD_W = 6;
    localparam int N_KINDS = 2;
    localparam int KIND_PAR = 0;
    localparam int KIND_FRM = 1;

    typedef struct packed {
        logic              perr;
        logic              ferr;
        logic [DATA_W-1:0] data;
    } rxq_entry_t;
endpackage

// File: rtl/rxq_store.sv
// Module: circular storage for queue entries with write and read pointers.
// The head entry is presented combinationally (show-ahead).
// Assumes the caller only strobes wr_en when not full and rd_en when not empty.
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  rxq_entry_t wr_entry,
    input  logic       rd_en,
    output rxq_entry_t head_entry
);
    rxq_entry_t      mem [DEPTH];
    logic [AW-1:0]   wr_ptr;
    logic [AW-1:0]   rd_ptr;

    // Advance a pointer by one position, wrapping at the last slot.
    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        if (p == AW'(DEPTH - 1)) begin
            return '0;
        end
        return p + AW'(1);
    endfunction

    // Write an accepted entry into its slot.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_ptr] <= wr_entry;
        end
    end

    // Move the two pointers on accepted writes and reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (wr_en) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (rd_en) begin
                rd_ptr <= bump(rd_ptr);
            end
        end
    end

    // Present the oldest entry.
    always_comb begin
        head_entry = mem[rd_ptr];
    end
endmodule

// File: rtl/rxq_occupancy.sv
// Module: occupancy counter from 0 to DEPTH, with full and empty flags.
// Assumes the accept strobes have already been qualified against full and empty.
module rxq_occupancy #(
    parameter int DEPTH = 64,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_ok,
    input  logic          pop_ok,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty
);
    // Count up on push and down on pop; leave the count alone when both or neither happen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= '0;
        end else begin
            unique case ({push_ok, pop_ok})
                2'b10:   level <= level + LW'(1);
                2'b01:   level <= level - LW'(1);
                default: level <= level;
            endcase
        end
    end

    // Derive the boundary flags from the count.
    always_comb begin
        full  = (level == LW'(DEPTH));
        empty = (level == '0);
    end
endmodule

// File: rtl/rxq_errtally.sv
// Module: exact count of stored entries that carry one kind of error flag.
// The count is wide enough to reach DEPTH without wrapping; the visible field truncates it.
// Assumes inc and dec are already qualified by accepted push and pop.
module rxq_errtally #(
    parameter int DEPTH = 64,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    output logic [LW-1:0] total
);
    // Apply the net change of this cycle (+1, -1 or 0).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            total <= '0;
        end else begin
            unique case ({inc, dec})
                2'b10:   total <= total + LW'(1);
                2'b01:   total <= total - LW'(1);
                default: total <= total;
            endcase
        end
    end
endmodule

// File: rtl/rxq_err_fifo.sv
// Module: receive byte queue with per-entry error flags and packed error tallies.
// A push is accepted only when the queue is not full; a push into a full queue
// sets a sticky overrun flag. A pop is accepted only when the queue is not empty.
// The count word masks both fields to 0 in synchronous mode.
// Assumes the count-word layout keeps 6-bit fields, so DEPTH should be 64 or less.
module rxq_err_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              async_mode,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              push_perr,
    input  logic              push_ferr,
    input  logic              pop,
    output logic [DATA_W-1:0] pop_data,
    output logic              pop_perr,
    output logic              pop_ferr,
    output logic              full,
    output logic              empty,
    output logic [LW-1:0]     level,
    output logic [15:0]       err_count_word,
    output logic              err_pending,
    output logic              overrun
);
    logic              push_ok;
    logic              pop_ok;
    rxq_entry_t        in_entry;
    rxq_entry_t        head;
    logic [N_KINDS-1:0] in_flag;
    logic [N_KINDS-1:0] head_flag;
    logic [LW-1:0]     tally [N_KINDS];
    logic [N_KINDS-1:0] kind_busy;
    logic [FIELD_W-1:0] par_field;
    logic [FIELD_W-1:0] frm_field;

    // Qualify the strobes against the current boundary flags.
    always_comb begin
        push_ok = push && !full;
        pop_ok  = pop && !empty;
    end

    // Bundle the incoming byte with its flags.
    always_comb begin
        in_entry.data = push_data;
        in_entry.perr = push_perr;
        in_entry.ferr = push_ferr;
    end

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (push_ok),
        .wr_entry   (in_entry),
        .rd_en      (pop_ok),
        .head_entry (head)
    );

    rxq_occupancy #(.DEPTH(DEPTH)) u_occ (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_ok (push_ok),
        .pop_ok  (pop_ok),
        .level   (level),
        .full    (full),
        .empty   (empty)
    );

    // Map the flags of the incoming and head entries onto the tally index order.
    always_comb begin
        in_flag[KIND_PAR]   = push_perr;
        in_flag[KIND_FRM]   = push_ferr;
        head_flag[KIND_PAR] = head.perr;
        head_flag[KIND_FRM] = head.ferr;
    end

    // One tally per error kind.
    for (genvar k = 0; k < N_KINDS; k++) begin : g_tally
        rxq_errtally #(.DEPTH(DEPTH)) u_tally (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (push_ok && in_flag[k]),
            .dec   (pop_ok && head_flag[k]),
            .total (tally[k])
        );
        assign kind_busy[k] = (tally[k] != '0);
    end

    // Record a dropped push until the next reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overrun <= 1'b0;
        end else if (push && full) begin
            overrun <= 1'b1;
        end
    end

    // Drive the head entry on the read outputs, or zeros when the queue is empty.
    always_comb begin
        pop_data = empty ? '0 : head.data;
        pop_perr = !empty && head.perr;
        pop_ferr = !empty && head.ferr;
    end

    // Pack the truncated tallies and mask them in synchronous mode.
    always_comb begin
        par_field      = tally[KIND_PAR][FIELD_W-1:0];
        frm_field      = tally[KIND_FRM][FIELD_W-1:0];
        err_count_word = '0;
        if (async_mode) begin
            err_count_word[8 +: FIELD_W] = par_field;
            err_count_word[0 +: FIELD_W] = frm_field;
        end
        err_pending = async_mode && (|kind_busy);
    end
endmodule

// File: rtl/rxq_err_fifo_chk.sv
// Module: property checker for rxq_err_fifo, attached through bind.
// Observes ports only; assumes a synchronous active-low reset.
module rxq_err_fifo_chk #(
    parameter int DEPTH = 64,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          async_mode,
    input logic          push,
    input logic          pop,
    input logic          full,
    input logic          empty,
    input logic [LW-1:0] level,
    input logic [15:0]   err_count_word,
    input logic          err_pending,
    input logic          overrun
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH)); // R3
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (full && $stable(level))); // R3
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun); // R3
    AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push) |=> overrun); // R3
    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> empty); // R4
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (err_count_word[15:14] == 2'b00) && (err_count_word[7:6] == 2'b00)); // R7
    AST_BOTH_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !full && !empty) |=> $stable(level)); // R9
    AST_SYNC_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        !async_mode |-> (err_count_word == 16'h0000 && !err_pending)); // R10
    AST_PEND_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (async_mode && err_count_word != 16'h0000) |-> err_pending); // R11
    AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !err_pending); // R11
endmodule

bind rxq_err_fifo rxq_err_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .async_mode     (async_mode),
    .push           (push),
    .pop            (pop),
    .full           (full),
    .empty          (empty),
    .level          (level),
    .err_count_word (err_count_word),
    .err_pending    (err_pending),
    .overrun        (overrun)
);

// File: tb/rxq_err_fifo_test.sv
// Directed bench for rxq_err_fifo, with a queue model of the expected contents.
module rxq_err_fifo_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        async_mode = 1'b1;
    logic        push = 1'b0;
    logic [7:0]  push_data = '0;
    logic        push_perr = 1'b0;
    logic        push_ferr = 1'b0;
    logic        pop = 1'b0;
    logic [7:0]  pop_data;
    logic        pop_perr;
    logic        pop_ferr;
    logic        full;
    logic        empty;
    logic [6:0]  level;
    logic [15:0] err_count_word;
    logic        err_pending;
    logic        overrun;

    int checks = 0;
    int errors = 0;
    logic [9:0] model[$];
    logic       exp_ovr = 1'b0;

    rxq_err_fifo uut (.*);

    always #5 clk = ~clk;

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Compare all outputs against the model; entry = {perr, ferr, data}.
    task automatic check_all(input string req);
        int pc = 0;
        int fc = 0;
        logic [15:0] w;
        foreach (model[i]) begin
            pc += int'(model[i][9]);
            fc += int'(model[i][8]);
        end
        w = async_mode ? {2'b00, 6'(pc), 2'b00, 6'(fc)} : 16'h0;
        chk({req, " level"}, 32'(level), 32'(model.size()));
        chk({req, " empty"}, 32'(empty), 32'(model.size() == 0));
        chk({req, " full"}, 32'(full), 32'(model.size() == 64));
        chk({req, " word"}, 32'(err_count_word), 32'(w));
        chk({req, " pending"}, 32'(err_pending), 32'(async_mode && (pc + fc) > 0));
        chk({req, " overrun"}, 32'(overrun), 32'(exp_ovr));
        if (model.size() > 0)
            chk({req, " head"}, {22'h0, pop_perr, pop_ferr, pop_data}, 32'(model[0]));
        else
            chk({req, " head"}, {22'h0, pop_perr, pop_ferr, pop_data}, 32'h0);
    endtask

    // One clock cycle with the given strobes; model is updated with the same rules.
    task automatic op(input logic pu, input logic po, input logic [7:0] d,
                      input logic p, input logic f);
        bit wok = pu && model.size() < 64;
        bit rok = po && model.size() > 0;
        push = pu; pop = po; push_data = d; push_perr = p; push_ferr = f;
        @(posedge clk);
        #1;
        push = 1'b0; pop = 1'b0;
        if (pu && !wok) exp_ovr = 1'b1;
        if (rok) void'(model.pop_front());
        if (wok) model.push_back({p, f, d});
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        model.delete();
        exp_ovr = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check_all("R1 reset");
    endtask

    task automatic t_order();
        op(1, 0, 8'hA1, 1, 0); check_all("R5 parity push");
        op(1, 0, 8'h52, 0, 1); check_all("R6 framing push");
        op(1, 0, 8'hC3, 1, 1); check_all("R11 both flags");
        op(1, 0, 8'h04, 0, 0); check_all("R2 clean push");
        for (int i = 0; i < 4; i++) begin
            op(0, 1, 8'h00, 0, 0);
            check_all("R2 ordered pop");
        end
    endtask

    task automatic t_empty_pop();
        op(0, 1, 8'h00, 0, 0); check_all("R4 pop empty");
        op(0, 1, 8'h00, 0, 0); check_all("R4 pop empty again");
    endtask

    task automatic t_fill();
        for (int i = 0; i < 64; i++) op(1, 0, 8'(i + 16), 1, i[0]);
        check_all("R8 full of parity");
        chk("R8 parity field wraps", 32'(err_count_word[13:8]), 32'h0);
        chk("R8 pending", 32'(err_pending), 32'h1);
        chk("R7 reserved", 32'({err_count_word[15:14], err_count_word[7:6]}), 32'h0);
        op(1, 0, 8'hEE, 0, 0); check_all("R3 drop when full");
        op(1, 1, 8'hEF, 1, 1); check_all("R3 drop with pop");
        for (int i = 0; i < 63; i++) begin
            op(0, 1, 8'h00, 0, 0);
            if (i % 8 == 0) check_all("R3 drain intact");
        end
        check_all("R3 sticky overrun");
        op(0, 1, 8'h00, 0, 0); check_all("R3 drained");
    endtask

    task automatic t_both();
        op(1, 0, 8'h11, 1, 0);
        op(1, 0, 8'h22, 0, 1);
        op(1, 1, 8'h33, 0, 1); check_all("R9 swap parity for framing");
        op(1, 1, 8'h44, 1, 1); check_all("R9 swap framing for both");
        op(1, 1, 8'h55, 0, 0); check_all("R9 pop flagged push clean");
        op(1, 1, 8'h66, 0, 0); check_all("R9 both flagged out");
    endtask

    task automatic t_sync();
        op(1, 0, 8'h77, 1, 1);
        async_mode = 1'b0; #1;
        check_all("R10 sync masks");
        op(1, 0, 8'h88, 1, 0); check_all("R10 sync push");
        op(0, 1, 8'h00, 0, 0); check_all("R10 sync pop");
        async_mode = 1'b1; #1;
        check_all("R10 async restored");
        while (model.size() > 0) op(0, 1, 8'h00, 0, 0);
        check_all("R11 empty no pending");
    endtask

    initial begin
        t_reset();
        t_order();
        t_empty_pop();
        t_fill();
        t_both();
        t_sync();
        do_reset();
        check_all("R1 reset clears overrun");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule